// File: doc/BRIEF.md
# Multi-Mode Pattern Generator

This block produces an eight-bit registered output pattern for bring-up and loopback testing. A three-bit mode selects the pattern source. Some modes show internal state: an up-counter, a walking one, or an eight-bit linear feedback shift register. The other modes are combinational forms of a stored byte and the live probe bus: the byte itself, the byte inverted, the probes mirrored, or the probes XORed with the byte.

A six-bit prescaler sets how fast the internal sequences step. The counter, the walking one and the LFSR step together on the prescaler tick, whatever mode is currently selected. Mode, divider and stored byte come from an external configuration decoder. The block treats them as plain levels and applies them on the next clock edge.

Top module: `patgen_top`

## Requirements
- R1: While reset is low and directly after it is released, the output, the counter and the walking-one state are zero, and the LFSR holds its seed 0x01.
- R2: On each clock the prescaler ticks if its elapsed count is greater than or equal to the divider N, and then restarts from zero. The sequences therefore step once every N+1 clocks, every clock when N is 0, and on the next clock if N is lowered below the elapsed count.
- R3: Mode 0 outputs the stored byte and mode 4 outputs its bitwise inverse.
- R4: Mode 1 outputs the counter, which increments by one on each tick and wraps from 0xFF to 0x00.
- R5: Mode 2 outputs the walking one. The first tick after reset loads 0x01. Each later tick rotates it left by one, so 0x80 is followed by 0x01.
- R6: Mode 3 outputs the LFSR. Each tick shifts it left and feeds bit7^bit5^bit4^bit3 into bit 0 (x^8+x^6+x^5+x^4+1). It is never zero, and a zero state is forced back to the seed.
- R7: Mode 5 outputs the probe bus. Modes 6 and 7 both output the probe bus XOR the stored byte.
- R8: The output is registered. It reflects the mode, probes, stored byte and sequence state present before the most recent clock edge.
- R10: The sequences keep stepping while a mode that does not display them is selected. Switching to mode 1 then shows the advanced count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| modeSel | input | 3 | Pattern mode, codes 0 to 7 |
| stepDiv | input | 6 | Prescaler divider N, one step every N+1 clocks |
| patA | input | 8 | Stored pattern byte |
| probe | input | 8 | Live probe bus |
| patOut | output | 8 | Registered pattern output |

## Verification
The sequence registers are visible only through the output. A bad counter, walking-one or LFSR step therefore appears one clock after the affected state is selected. A corrupted state that is not being displayed stays hidden until its mode is chosen, and the bench selects it after long runs in other modes to expose that. A prescaler fault shows as a step spacing different from N+1 clocks in mode 1. Mirror and XOR faults show one clock after any probe change.

// File: rtl/patgen_pkg.sv
package patgen_pkg;

  localparam int MODE_BITS = 3;

  typedef enum logic [MODE_BITS-1:0] {
    MODE_HOLD    = 3'd0,
    MODE_COUNT   = 3'd1,
    MODE_WALK    = 3'd2,
    MODE_LFSR    = 3'd3,
    MODE_INV     = 3'd4,
    MODE_MIRROR  = 3'd5,
    MODE_XOR     = 3'd6,
    MODE_XOR_ALT = 3'd7
  } patMode_e;

  typedef struct packed {
    logic     step;
    patMode_e mode;
  } patCtl_t;

endpackage

// File: rtl/patgen_ctrl.sv
module patgen_ctrl
  import patgen_pkg::*;
#(
  parameter int DIV_BITS = 6
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [MODE_BITS-1:0] modeSel,
  input  logic [DIV_BITS-1:0] stepDiv,
  output patCtl_t             ctl
);

  logic [DIV_BITS-1:0] tickCnt;
  logic                tickHit;

  // A lowered divider that falls below the elapsed count fires at once.
  assign tickHit = (tickCnt >= stepDiv);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tickCnt <= '0;
    end else if (tickHit) begin
      tickCnt <= '0;
    end else begin
      tickCnt <= tickCnt + 1'b1;
    end
  end

  always_comb begin
    ctl.step = tickHit;
    ctl.mode = patMode_e'(modeSel);
  end

  AST_TICK_ADVANCE: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.step |=> tickCnt == DIV_BITS'($past(tickCnt) + 1'b1)); // R2

  AST_TICK_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    ctl.step |=> tickCnt == '0); // R2

endmodule

// File: rtl/patgen_dp.sv
module patgen_dp
  import patgen_pkg::*;
#(
  parameter int           W         = 8,
  parameter logic [W-1:0] LFSR_SEED = 8'h01,
  parameter logic [W-1:0] LFSR_TAPS = 8'hB8
) (
  input  logic         clk,
  input  logic         rstN,
  input  patCtl_t      ctl,
  input  logic [W-1:0] patA,
  input  logic [W-1:0] probe,
  output logic [W-1:0] patOut
);

  localparam logic [W-1:0] WALK_START = W'(1);

  logic [W-1:0] cntQ, walkQ, lfsrQ;
  logic [W-1:0] walkNext, lfsrNext, lfsrShift, outNext;
  logic [W-1:0] tapBits;
  logic         lfsrFb;

  // Tapped bits gathered per position; the feedback is their parity.
  for (genvar i = 0; i < W; i++) begin : gTap
    if (LFSR_TAPS[i]) begin : gOn
      assign tapBits[i] = lfsrQ[i];
    end else begin : gOff
      assign tapBits[i] = 1'b0;
    end
  end

  assign lfsrFb    = ^tapBits;
  assign lfsrShift = {lfsrQ[W-2:0], lfsrFb};
  assign lfsrNext  = (lfsrQ == '0 || lfsrShift == '0) ? LFSR_SEED : lfsrShift;
  assign walkNext  = (walkQ == '0) ? WALK_START : {walkQ[W-2:0], walkQ[W-1]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ  <= '0;
      walkQ <= '0;
      lfsrQ <= LFSR_SEED;
    end else if (ctl.step) begin
      cntQ  <= cntQ + 1'b1;
      walkQ <= walkNext;
      lfsrQ <= lfsrNext;
    end
  end

  always_comb begin
    unique case (ctl.mode)
      MODE_HOLD:    outNext = patA;
      MODE_COUNT:   outNext = cntQ;
      MODE_WALK:    outNext = walkQ;
      MODE_LFSR:    outNext = lfsrQ;
      MODE_INV:     outNext = ~patA;
      MODE_MIRROR:  outNext = probe;
      MODE_XOR,
      MODE_XOR_ALT: outNext = probe ^ patA;
      default:      outNext = patA;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      patOut <= '0;
    end else begin
      patOut <= outNext;
    end
  end

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    ctl.step |=> cntQ == W'($past(cntQ) + 1'b1)); // R4

  AST_CNT_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.step |=> $stable(cntQ) && $stable(walkQ) && $stable(lfsrQ)); // R2

  AST_WALK_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(walkQ)); // R5

  AST_LFSR_NONZERO: assert property (@(posedge clk) disable iff (!rstN)
    lfsrQ != '0); // R6

  AST_MIRROR_OUT: assert property (@(posedge clk) disable iff (!rstN)
    ctl.mode == MODE_MIRROR |=> patOut == $past(probe)); // R7

  AST_XOR_ALIAS: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.mode == MODE_XOR || ctl.mode == MODE_XOR_ALT)
      |=> patOut == $past(probe ^ patA)); // R7

  AST_INV_OUT: assert property (@(posedge clk) disable iff (!rstN)
    ctl.mode == MODE_INV |=> patOut == ~$past(patA)); // R3

endmodule

// File: rtl/patgen_top.sv
module patgen_top
  import patgen_pkg::*;
#(
  parameter int           W         = 8,
  parameter int           DIV_BITS  = 6,
  parameter logic [W-1:0] LFSR_SEED = 8'h01,
  parameter logic [W-1:0] LFSR_TAPS = 8'hB8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [MODE_BITS-1:0] modeSel,
  input  logic [DIV_BITS-1:0]  stepDiv,
  input  logic [W-1:0]         patA,
  input  logic [W-1:0]         probe,
  output logic [W-1:0]         patOut
);

  patCtl_t ctl;

  patgen_ctrl #(
    .DIV_BITS(DIV_BITS)
  ) uCtrl (
    .clk    (clk),
    .rstN   (rstN),
    .modeSel(modeSel),
    .stepDiv(stepDiv),
    .ctl    (ctl)
  );

  patgen_dp #(
    .W        (W),
    .LFSR_SEED(LFSR_SEED),
    .LFSR_TAPS(LFSR_TAPS)
  ) uDp (
    .clk   (clk),
    .rstN  (rstN),
    .ctl   (ctl),
    .patA  (patA),
    .probe (probe),
    .patOut(patOut)
  );

  AST_RESET_OUT: assert property (@(posedge clk)
    !rstN |-> patOut == '0); // R1

endmodule

// File: tb/sim_patgen_top.sv
module sim_patgen_top;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] modeSel = 3'd0;
  logic [5:0] stepDiv = 6'd0;
  logic [7:0] patA = 8'h00;
  logic [7:0] probe = 8'h00;
  logic [7:0] patOut;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  patgen_top u0 (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .stepDiv(stepDiv),
    .patA(patA), .probe(probe), .patOut(patOut)
  );

  // Reference model, written from the requirements.
  logic [5:0] mTick = '0;
  logic [7:0] mCnt = '0, mWalk = '0, mLfsr = 8'h01, mOut = '0;

  function automatic logic [7:0] lfsrStep(input logic [7:0] s);
    logic [7:0] n;
    n = {s[6:0], s[7] ^ s[5] ^ s[4] ^ s[3]};
    return (n == 8'h00) ? 8'h01 : n;
  endfunction

  function automatic logic [7:0] expOut(input logic [2:0] m);
    case (m)
      3'd0: return patA;
      3'd1: return mCnt;
      3'd2: return mWalk;
      3'd3: return mLfsr;
      3'd4: return ~patA;
      3'd5: return probe;
      default: return probe ^ patA;
    endcase
  endfunction

  function automatic string tagOf(input logic [2:0] m);
    case (m)
      3'd0, 3'd4: return "R3";
      3'd1: return "R4";
      3'd2: return "R5";
      3'd3: return "R6";
      default: return "R7";
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mTick = '0; mCnt = '0; mWalk = '0; mLfsr = 8'h01; mOut = '0;
    end else begin
      mOut = expOut(modeSel);
      if (mTick >= stepDiv) begin
        mTick = '0;
        mCnt  = mCnt + 8'd1;
        mWalk = (mWalk == 8'h00) ? 8'h01 : {mWalk[6:0], mWalk[7]};
        mLfsr = lfsrStep(mLfsr);
      end else begin
        mTick = mTick + 6'd1;
      end
    end
  end

  task automatic checkVal(input string tag, input logic [7:0] exp);
    checks++;
    if (patOut !== exp) begin
      errors++;
      $display("FAIL %s: patOut=%02h expected=%02h at %0t", tag, patOut, exp, $time);
    end
  endtask

  task automatic cyc(input string tag);
    @(posedge clk);
    #1;
    checkVal(tag, mOut);
  endtask

  task automatic doReset();
    rstN = 1'b0;
    @(posedge clk);
    #1;
    checkVal("R1", 8'h00);
    rstN = 1'b1;
    checkVal("R1", 8'h00);
  endtask

  task automatic finish();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: run did not finish");
    finish();
  end

  initial begin
    process::self().srandom(32'd20240611);
    #(CLK_PERIOD * 2 + 1);
    // R1: reset state seen in counter, walk and LFSR modes
    doReset();
    stepDiv = 6'd63;
    modeSel = 3'd1; cyc("R1"); checkVal("R1", 8'h00);
    modeSel = 3'd2; cyc("R1"); checkVal("R1", 8'h00);
    modeSel = 3'd3; cyc("R1"); checkVal("R1", 8'h01);

    // R2: divider 3 steps the counter every 4 clocks
    doReset();
    stepDiv = 6'd3; modeSel = 3'd1;
    for (int i = 0; i < 24; i++) cyc("R2");
    stepDiv = 6'd63;
    for (int i = 0; i < 10; i++) cyc("R2");
    stepDiv = 6'd1; // lowered below elapsed count
    for (int i = 0; i < 6; i++) cyc("R2");

    // R4: counter wrap at divider 0
    doReset();
    stepDiv = 6'd0; modeSel = 3'd1;
    for (int i = 0; i < 262; i++) cyc("R4");

    // R5: walking one including 0x80 to 0x01
    doReset();
    modeSel = 3'd2;
    for (int i = 0; i < 20; i++) cyc("R5");

    // R6: LFSR from seed; first two values fixed
    doReset();
    modeSel = 3'd3;
    cyc("R6"); checkVal("R6", 8'h01);
    cyc("R6"); checkVal("R6", 8'h02);
    for (int i = 0; i < 40; i++) cyc("R6");

    // R3, R7 and R8: combinational modes, one clock of latency
    patA = 8'h5A; probe = 8'hC3;
    modeSel = 3'd0; cyc("R3"); checkVal("R3", 8'h5A);
    modeSel = 3'd4; cyc("R3"); checkVal("R3", 8'hA5);
    modeSel = 3'd5; cyc("R7"); checkVal("R7", 8'hC3);
    modeSel = 3'd6; cyc("R7"); checkVal("R7", 8'h99);
    modeSel = 3'd7; cyc("R7"); checkVal("R7", 8'h99);
    modeSel = 3'd5; cyc("R8");
    probe = 8'h3C; #2;
    checkVal("R8", 8'hC3); // not yet sampled
    cyc("R8"); checkVal("R8", 8'h3C);

    // R10: counter keeps running while hidden
    doReset();
    stepDiv = 6'd0; modeSel = 3'd0;
    for (int i = 0; i < 20; i++) cyc("R10");
    modeSel = 3'd1; cyc("R10"); checkVal("R10", 8'd20);

    // Random mix of modes, dividers and data
    for (int i = 0; i < 800; i++) begin
      if (i % 9 == 0) begin
        modeSel = 3'($urandom_range(0, 7));
        stepDiv = ($urandom_range(0, 3) == 0) ? 6'd63 : 6'($urandom_range(0, 5));
      end
      patA  = 8'($urandom);
      probe = 8'($urandom);
      cyc(tagOf(modeSel));
    end

    finish();
  end

endmodule